// File: doc/BRIEF.md
# Receive Character Queue with Error Accumulation

This block sits between a serial receiver's deserializer and the CPU-side register file. Each assembled character arrives with a one-cycle valid pulse, together with three condition flags: parity error, framing error and line break. The character first lands in a single holding stage. From there it moves into a three-slot first-in first-out store as soon as a slot is free, so up to four characters can be waiting at once. The CPU sees the oldest character on a data output and removes it with a pop pulse.

The status outputs report the flags in one of two ways. In per-character mode they show the flags of the oldest stored character only. In accumulated mode they show the OR of the flags of every character that has become the oldest since the last error-clear command. The block also detects overrun: a new start bit arriving while the store is full and the holding stage is occupied sets a flag, and the incoming character then replaces the held one. A ready-to-receive output can be driven automatically from start-bit and full events for hardware flow control.

A receiver-reset command empties everything. Disabling the receiver discards only the character in the holding stage, and the stored characters remain readable.

Top module: `rx_char_queue`

## Requirements
- R1: Four characters written with no pop are all kept: three in the store and one in the holding stage. Popping then returns them in arrival order, and when the store has no free slot the holding stage neither moves nor is lost.
- R2: Each stored entry keeps its 8-bit data with its parity, framing and break flags. `rd_data` shows the oldest entry's data, and a pop removes that entry so the next one shows from the following cycle.
- R3: A character accepted by `char_valid` at clock edge k sits in the holding stage. If a slot is free after any pop at edge k+1, it enters the store at that edge. `rx_ready` is 1 while the store holds at least one entry, and `fifo_full` is 1 while it holds exactly three.
- R4: With `block_mode`=0, `stat_perr`/`stat_ferr`/`stat_brk` equal the flags of the oldest stored entry, and all three are 0 when the store is empty.
- R5: With `block_mode`=1, the status flags are the OR of the flags of every entry that has become the oldest since the last `err_reset`. They stay set after the store empties.
- R6: If `start_det` arrives while the store is full and the holding stage is occupied, `overrun` sets at that edge. A following character overwrites the held character, and the store is left untouched.
- R7: `rtr_set` drives `rtr` to 1. With `autoflow`=1, a `start_det` while the store is full drops `rtr` to 0. It returns to 1 on its own once the store is seen with fewer than three entries.
- R8: `rx_reset` (or `rst_n` low) empties the store and the holding stage, and clears `overrun`, the accumulated flags and `rtr`.
- R9: While `rx_en`=0, the holding stage is discarded and `char_valid`/`start_det` have no effect. Stored entries can still be popped.
- R10: `err_reset` clears `overrun` and the accumulated flags at one edge. An overrun condition or a new oldest entry in that same cycle takes precedence and sets its flags.
- R11: A pop while the store is empty changes nothing, and `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable level |
| rx_reset | input | 1 | Receiver reset command pulse |
| err_reset | input | 1 | Error-clear command pulse |
| block_mode | input | 1 | 1 = accumulated status, 0 = per-character status |
| autoflow | input | 1 | Enables automatic ready-to-receive control |
| rtr_set | input | 1 | Software assertion of ready-to-receive |
| start_det | input | 1 | Start bit detected pulse |
| char_valid | input | 1 | Assembled character valid pulse |
| char_data | input | 8 | Assembled character data |
| char_perr | input | 1 | Parity error of the assembled character |
| char_ferr | input | 1 | Framing error of the assembled character |
| char_brk | input | 1 | Break flag of the assembled character |
| pop | input | 1 | Remove the oldest entry (data read) |
| rd_data | output | 8 | Oldest entry's data, 0 when empty |
| rx_ready | output | 1 | Store not empty |
| fifo_full | output | 1 | Store holds three entries |
| stat_perr | output | 1 | Parity error status |
| stat_ferr | output | 1 | Framing error status |
| stat_brk | output | 1 | Break status |
| overrun | output | 1 | Overrun flag |
| rtr | output | 1 | Ready-to-receive output |

## Verification
The hardest states to reach are the ones where two events meet at one edge. Examples are an error-clear command arriving in the same cycle as a new oldest entry or an overrun, and a pop that frees a slot in the same cycle the held character moves in, so that the store stays full and `rtr` stays low. Directed sequences get there by filling the store and the holding stage with exact two-cycle character pulses, then issuing the pop or clear on a chosen cycle. A long run of seeded random pulses and mode changes then drives further coincidences. A behavioural queue model is compared against every output on every cycle.

// File: rtl/rxq_pkg.sv
// Shared types for the receive character queue.
package rxq_pkg;
    // Per-character condition flags, kept with the data in each entry.
    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rxq_flags_t;

    localparam int FLAG_W = $bits(rxq_flags_t);
endpackage

// File: rtl/rxq_store.sv
// Circular first-in first-out store of DEPTH entries, each W bits wide.
// Assumes the caller never pushes into a full store (unless popping in the
// same cycle) and never pops an empty one. Shows the oldest entry and the
// one behind it.
module rxq_store #(
    parameter int W     = 11,
    parameter int DEPTH = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [W-1:0]                   push_d,
    input  logic                           pop,
    output logic [W-1:0]                   head_q,
    output logic [W-1:0]                   next_q,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // One write port per slot, selected by the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(i)) mem[i] <= push_d;
        end
    end

    assign head_q = mem[rd_ptr];
    assign next_q = mem[bump(rd_ptr)];

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CNT_W'(DEPTH)));
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/rxq_errs.sv
// Accumulated error flags and the overrun flag. The clear command yields to
// a set arriving in the same cycle.
module rxq_errs
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              err_clr,
    input  logic              arrive,
    input  logic [FLAG_W-1:0] arrive_flags,
    input  logic              ovr_set,
    output logic [FLAG_W-1:0] acc,
    output logic              overrun
);
    // OR in the flags of each new oldest entry; clear on command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc     <= '0;
            overrun <= 1'b0;
        end else begin
            acc     <= (err_clr ? '0 : acc) | (arrive ? arrive_flags : '0);
            overrun <= (overrun && !err_clr) || ovr_set;
        end
    end

    // R10
    err_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !ovr_set && !clr) |=> !overrun);
endmodule

// File: rtl/rxq_flow.sv
// Ready-to-receive control: set by software, dropped on a start bit while
// full (automatic mode), restored once a slot is free again.
module rxq_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sw_set,
    input  logic auto_en,
    input  logic start_ok,
    input  logic full,
    output logic rtr
);
    logic parked;

    // Track the output and whether the flow logic itself dropped it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rtr    <= 1'b0;
            parked <= 1'b0;
        end else if (sw_set) begin
            rtr    <= 1'b1;
            parked <= 1'b0;
        end else if (auto_en && start_ok && full) begin
            rtr    <= 1'b0;
            parked <= 1'b1;
        end else if (parked && !full) begin
            rtr    <= 1'b1;
            parked <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_char_queue.sv
// Receive character queue: a holding stage feeding a DEPTH-entry store, with
// per-character or accumulated error status, overrun detection and
// automatic ready-to-receive control. Assumes single-cycle input pulses.
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_reset,
    input  logic              err_reset,
    input  logic              block_mode,
    input  logic              autoflow,
    input  logic              rtr_set,
    input  logic              start_det,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              char_brk,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              stat_perr,
    output logic              stat_ferr,
    output logic              stat_brk,
    output logic              overrun,
    output logic              rtr
);
    localparam int ENT_W = DATA_W + FLAG_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENT_W-1:0]  hold_q;
    logic              hold_valid;
    logic [ENT_W-1:0]  head_q;
    logic [ENT_W-1:0]  next_q;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  cnt_after;
    logic              pop_ok;
    logic              move;
    logic              arrive;
    logic [FLAG_W-1:0] arrive_flags;
    logic [FLAG_W-1:0] acc;
    rxq_flags_t        head_flags;
    rxq_flags_t        in_flags;
    logic              start_ok;

    assign in_flags   = '{brk: char_brk, ferr: char_ferr, perr: char_perr};
    assign pop_ok     = pop && (count != '0);
    assign cnt_after  = count - CNT_W'(pop_ok);
    assign move       = rx_en && hold_valid && (cnt_after < CNT_W'(DEPTH));
    assign start_ok   = rx_en && start_det;
    assign fifo_full  = (count == CNT_W'(DEPTH));
    assign rx_ready   = (count != '0);

    // A new oldest entry appears either behind a pop or by entering empty.
    assign arrive       = (pop_ok && count > CNT_W'(1)) || (move && cnt_after == '0);
    assign arrive_flags = (pop_ok && count > CNT_W'(1)) ? next_q[DATA_W +: FLAG_W]
                                                         : hold_q[DATA_W +: FLAG_W];

    // Holding stage: load on each character, empty on move or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_reset || !rx_en) begin
            hold_valid <= 1'b0;
            hold_q     <= '0;
        end else if (char_valid) begin
            hold_valid <= 1'b1;
            hold_q     <= {in_flags, char_data};
        end else if (move) begin
            hold_valid <= 1'b0;
        end
    end

    rxq_store #(.W(ENT_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_reset),
        .push   (move),
        .push_d (hold_q),
        .pop    (pop_ok),
        .head_q (head_q),
        .next_q (next_q),
        .count  (count)
    );

    rxq_errs u_errs (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (rx_reset),
        .err_clr      (err_reset),
        .arrive       (arrive),
        .arrive_flags (arrive_flags),
        .ovr_set      (start_ok && hold_valid && fifo_full),
        .acc          (acc),
        .overrun      (overrun)
    );

    rxq_flow u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_reset),
        .sw_set   (rtr_set),
        .auto_en  (autoflow),
        .start_ok (start_ok),
        .full     (fifo_full),
        .rtr      (rtr)
    );

    // Select status source by error mode; data reads zero when empty.
    assign head_flags = head_q[DATA_W +: FLAG_W];
    always_comb begin
        rd_data = rx_ready ? head_q[DATA_W-1:0] : '0;
        if (block_mode) begin
            {stat_brk, stat_ferr, stat_perr} = acc;
        end else if (rx_ready) begin
            {stat_brk, stat_ferr, stat_perr} = {head_flags.brk, head_flags.ferr, head_flags.perr};
        end else begin
            {stat_brk, stat_ferr, stat_perr} = '0;
        end
    end

    // R6
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(start_det && rx_en && fifo_full));
    // R7
    rtr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rtr) |-> $past(rx_reset || start_det));
    // R8
    rx_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (!rx_ready && !overrun && !rtr));
    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rx_ready && !rx_reset && !(rx_en && hold_valid)) |=> !rx_ready);
endmodule

// File: tb/rx_char_queue_bench.sv
module rx_char_queue_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, rx_en, rx_reset, err_reset, block_mode, autoflow, rtr_set;
    logic       start_det, char_valid, char_perr, char_ferr, char_brk, pop;
    logic [7:0] char_data, rd_data;
    logic       rx_ready, fifo_full, stat_perr, stat_ferr, stat_brk, overrun, rtr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    rx_char_queue u_rx_char_queue (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_reset(rx_reset),
        .err_reset(err_reset), .block_mode(block_mode), .autoflow(autoflow),
        .rtr_set(rtr_set), .start_det(start_det), .char_valid(char_valid),
        .char_data(char_data), .char_perr(char_perr), .char_ferr(char_ferr),
        .char_brk(char_brk), .pop(pop), .rd_data(rd_data), .rx_ready(rx_ready),
        .fifo_full(fifo_full), .stat_perr(stat_perr), .stat_ferr(stat_ferr),
        .stat_brk(stat_brk), .overrun(overrun), .rtr(rtr)
    );

    // Reference model: entry = {brk, ferr, perr, data}
    logic [10:0] m_q[$];
    logic [10:0] m_hold;
    bit          m_hold_v, m_ovr, m_rtr, m_park;
    logic [2:0]  m_acc;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step();
        int  cnt;
        bit  pop_ok, mv, arr, ovr_set, neg;
        logic [2:0] af;
        if (!rst_n || rx_reset) begin
            m_q.delete(); m_hold_v = 0; m_ovr = 0; m_rtr = 0; m_park = 0; m_acc = 0;
            return;
        end
        cnt     = m_q.size();
        pop_ok  = pop && cnt > 0;
        ovr_set = rx_en && start_det && m_hold_v && cnt == 3;
        neg     = autoflow && rx_en && start_det && cnt == 3;
        arr = 0; af = 0;
        if (pop_ok) begin
            void'(m_q.pop_front());
            if (m_q.size() > 0) begin arr = 1; af = m_q[0][10:8]; end
        end
        mv = rx_en && m_hold_v && m_q.size() < 3;
        if (mv) begin
            if (m_q.size() == 0) begin arr = 1; af = m_hold[10:8]; end
            m_q.push_back(m_hold);
        end
        if (!rx_en) m_hold_v = 0;
        else if (char_valid) begin
            m_hold_v = 1; m_hold = {char_brk, char_ferr, char_perr, char_data};
        end else if (mv) m_hold_v = 0;
        if (err_reset) m_acc = 0;
        if (arr) m_acc = m_acc | af;
        if (err_reset) m_ovr = 0;
        if (ovr_set) m_ovr = 1;
        if (rtr_set) begin m_rtr = 1; m_park = 0; end
        else if (neg) begin m_rtr = 0; m_park = 1; end
        else if (m_park && cnt < 3) begin m_rtr = 1; m_park = 0; end
    endtask

    task automatic compare_all();
        int n = m_q.size();
        check("R2 rd_data", rd_data, n > 0 ? int'(m_q[0][7:0]) : 0);
        check("R3 rx_ready", rx_ready, n > 0);
        check("R3 fifo_full", fifo_full, n == 3);
        if (block_mode)
            check("R5 accumulated flags", {stat_brk, stat_ferr, stat_perr}, m_acc);
        else
            check("R4 head flags", {stat_brk, stat_ferr, stat_perr}, n > 0 ? int'(m_q[0][10:8]) : 0);
        check("R6 overrun", overrun, m_ovr);
        check("R7 rtr", rtr, m_rtr);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        start_det = 0; char_valid = 0; pop = 0; err_reset = 0; rx_reset = 0; rtr_set = 0;
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] f);
        start_det = 1;
        tick();
        char_valid = 1; char_data = d; {char_brk, char_ferr, char_perr} = f;
        tick();
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] d);
        check(tag, rd_data, d);
        pop = 1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_en = 1; rx_reset = 0; err_reset = 0; block_mode = 0; autoflow = 1;
        rtr_set = 0; start_det = 0; char_valid = 0; char_data = 0;
        char_perr = 0; char_ferr = 0; char_brk = 0; pop = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R8 reset state
        check("R8 reset rx_ready", rx_ready, 0);
        check("R8 reset rtr", rtr, 0);
        check("R8 reset overrun", overrun, 0);

        rtr_set = 1; tick();
        check("R7 software set", rtr, 1);

        // R1: four characters, no pop; R4 head flags
        send(8'h11, 3'b000); send(8'h22, 3'b001); send(8'h33, 3'b010); send(8'h44, 3'b100);
        tick(); tick();
        check("R3 full after four", fifo_full, 1);
        check("R1 rtr untouched without start", rtr, 1);
        pop_expect("R1 first", 8'h11);
        check("R4 perr of second", stat_perr, 1);
        pop_expect("R1 second", 8'h22);
        pop_expect("R1 third", 8'h33);
        pop_expect("R1 held fourth", 8'h44);
        check("R4 empty flags", {stat_brk, stat_ferr, stat_perr}, 0);

        // R6 overrun with R10 precedence, R7 flow drop
        send(8'hA1, 3'b000); send(8'hA2, 3'b000); send(8'hA3, 3'b000); send(8'hA4, 3'b000);
        tick();
        start_det = 1; err_reset = 1; tick();
        check("R6 overrun set", overrun, 1);
        check("R10 set beats clear", overrun, 1);
        check("R7 rtr dropped when full", rtr, 0);
        char_valid = 1; char_data = 8'hA5; {char_brk, char_ferr, char_perr} = 3'b000; tick();
        pop_expect("R6 keep first", 8'hA1);
        check("R7 still low while refilled", rtr, 0);
        pop_expect("R6 keep second", 8'hA2);
        pop_expect("R6 keep third", 8'hA3);
        pop_expect("R6 overwriter replaces held", 8'hA5);
        check("R7 restored", rtr, 1);
        err_reset = 1; tick();
        check("R10 overrun cleared", overrun, 0);

        // R5 block mode
        block_mode = 1; err_reset = 1; tick();
        send(8'h51, 3'b000); send(8'h52, 3'b001); send(8'h53, 3'b010);
        tick(); tick();
        check("R5 first only", {stat_brk, stat_ferr, stat_perr}, 3'b000);
        pop = 1; tick();
        check("R5 after second", {stat_brk, stat_ferr, stat_perr}, 3'b001);
        pop = 1; tick();
        pop = 1; tick();
        check("R5 sticky when empty", {stat_brk, stat_ferr, stat_perr}, 3'b011);
        err_reset = 1; tick();
        check("R10 accumulated cleared", {stat_brk, stat_ferr, stat_perr}, 3'b000);
        send(8'h61, 3'b000); send(8'h62, 3'b100);
        tick(); tick();
        err_reset = 1; pop = 1; tick();
        check("R10 arrival beats clear", {stat_brk, stat_ferr, stat_perr}, 3'b100);
        pop = 1; tick();
        err_reset = 1; tick();

        // R9 receiver disable
        block_mode = 0;
        send(8'h71, 3'b000); tick();
        send(8'h72, 3'b000);
        rx_en = 0; char_valid = 1; char_data = 8'h73; start_det = 1; tick();
        rx_en = 1; tick(); tick(); tick();
        check("R9 stored kept", rd_data, 8'h71);
        check("R9 not full", fifo_full, 0);
        pop = 1; tick();
        check("R9 held dropped", rx_ready, 0);

        // R11 empty pop
        pop = 1; tick();
        check("R11 data zero", rd_data, 0);
        check("R11 still empty", rx_ready, 0);

        // R8 receiver reset
        send(8'h81, 3'b001); send(8'h82, 3'b000); send(8'h83, 3'b000); send(8'h84, 3'b000);
        tick(); start_det = 1; tick();
        rx_reset = 1; tick();
        check("R8 cleared ready", rx_ready, 0);
        check("R8 cleared overrun", overrun, 0);
        check("R8 cleared rtr", rtr, 0);

        // Random mix against the model
        void'($urandom(7));
        for (int i = 0; i < 4000; i++) begin
            start_det  = ($urandom % 4) == 0;
            char_valid = ($urandom % 4) == 0;
            char_data  = 8'($urandom);
            {char_brk, char_ferr, char_perr} = 3'($urandom % 8 == 0 ? $urandom : 0);
            pop        = ($urandom % 5) == 0;
            err_reset  = ($urandom % 23) == 0;
            rtr_set    = ($urandom % 31) == 0;
            rx_reset   = ($urandom % 211) == 0;
            if (($urandom % 97) == 0) block_mode = ~block_mode;
            if (($urandom % 89) == 0) autoflow = ~autoflow;
            rx_en = ($urandom % 53) != 0;
            tick();
        end
        rx_en = 1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule